// File: doc/BRIEF.md
# T1 Framing Bit Error-Density Monitor

This block supervises an established T1 frame alignment. For every received frame the framer gives it a strobe, the frame's position in the superframe, the received framing bit and the bit that the alignment pattern predicts at that position. The block decides whether that framing bit counts, records whether it was wrong, and asks for a new alignment search with a one-cycle reframe pulse when too many of the recent counted bits were wrong.

Which bits count depends on the superframe format. In the extended format every framing bit counts. In the 12-frame format the terminal-framing bits in odd frames always count. The signalling-framing bits in even frames count only when that check is enabled. Frame 12's bit is left out when that frame carries the secondary remote alarm. The trip rule is two errors among the last 4, 5 or 6 counted bits, picked by a 2-bit select. A fourth select value turns automatic reframing off. A transparent input also blocks automatic reframes. A software request forces a reframe at any time.

Top module: `t1_fbit_density_mon`

## Requirements
- R1: With `esf_i`=1, every strobed frame's framing bit is counted, whatever its frame number and whatever the Fs-check and alarm inputs are.
- R2: With `esf_i`=0, odd frame numbers (bit 0 of `frame_num_i` = 1) are always counted. Even frame numbers are counted only when `fs_chk_i`=1.
- R3: With `esf_i`=0, `fs_chk_i`=1 and `sec_yel_i`=1, frame number 12 is not counted. The other even frames still are.
- R4: With `thr_sel_i`=2'b00, a counted error that leaves two errors among the last 4 counted bits raises a reframe. Errors 4 counted bits apart do not.
- R5: With `thr_sel_i`=2'b01 the window is 5 counted bits.
- R6: With `thr_sel_i`=2'b10 the window is 6 counted bits.
- R7: With `thr_sel_i`=2'b11 no automatic reframe is raised.
- R8: While `transparent_i`=1 no automatic reframe is raised.
- R9: `sw_reframe_i` high in a cycle makes `reframe_o` high in the next cycle, in any mode.
- R10: Every reframe empties the error history. `err_cnt_o` is 0 in the cycle `reframe_o` is high, and an automatic reframe lasts one cycle.
- R11: `err_cnt_o` is the number of errors among the last N counted bits. N is 4, 5, 6 or 6 for `thr_sel_i` = 00, 01, 10, 11. It updates the cycle after a counted strobe and holds while no bit is counted.
- R12: While `rst_ni`=0, `reframe_o`=0 and `err_cnt_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_stb_i | input | 1 | One-cycle strobe per received frame |
| frame_num_i | input | 5 | Frame position in the superframe, 1 to 24 or 1 to 12 |
| f_rx_i | input | 1 | Received framing bit |
| f_exp_i | input | 1 | Framing bit expected at this position |
| esf_i | input | 1 | 1 = 24-frame extended format, 0 = 12-frame format |
| fs_chk_i | input | 1 | 12-frame format: also count even-frame bits |
| sec_yel_i | input | 1 | 12-frame format: frame 12 carries the alarm and is not counted |
| thr_sel_i | input | 2 | Window select: 00 = 4, 01 = 5, 10 = 6, 11 = auto reframe off |
| transparent_i | input | 1 | Blocks automatic reframes |
| sw_reframe_i | input | 1 | Software reframe request |
| reframe_o | output | 1 | Reframe pulse, one cycle |
| err_cnt_o | output | 3 | Errors in the current window |

## Verification
The assertions assume that `frame_stb_i` lasts one cycle per frame. They also assume that `frame_num_i` stays within the superframe length of the selected format. The bench keeps to this by strobing a single cycle with an in-range frame number, then holding the strobe low until the next step. The stability property assumes that `thr_sel_i` changes only between strobes. The bench changes the select only on non-strobe cycles.

// File: rtl/t1_fbit_pkg.sv
package t1_fbit_pkg;
  localparam int unsigned WIN_MAX   = 6;
  localparam int unsigned CNT_W     = $clog2(WIN_MAX + 1);
  localparam int unsigned FN_W      = 5;
  localparam int unsigned TRIP_ERRS = 2;
  localparam int unsigned WIN_A     = 4;
  localparam int unsigned WIN_B     = 5;
  localparam int unsigned WIN_C     = 6;
  localparam int unsigned ALARM_FN  = 12;

  typedef enum logic [1:0] {
    THR_A   = 2'd0,
    THR_B   = 2'd1,
    THR_C   = 2'd2,
    THR_OFF = 2'd3
  } thr_sel_e;

  function automatic logic [CNT_W-1:0] win_len(thr_sel_e s);
    case (s)
      THR_A:   return CNT_W'(WIN_A);
      THR_B:   return CNT_W'(WIN_B);
      default: return CNT_W'(WIN_C);
    endcase
  endfunction
endpackage

// File: rtl/t1_fbit_qual.sv
module t1_fbit_qual #(
  parameter int unsigned FN_W     = 5,
  parameter int unsigned ALARM_FN = 12
) (
  input  logic            stb_i,
  input  logic [FN_W-1:0] fn_i,
  input  logic            esf_i,
  input  logic            fs_chk_i,
  input  logic            sec_yel_i,
  output logic            chk_o
);
  logic is_fs, is_alarm;

  assign is_fs    = ~fn_i[0];
  assign is_alarm = (fn_i == FN_W'(ALARM_FN));

  // odd frames carry Ft, even frames Fs in the 12-frame format
  assign chk_o = stb_i & (esf_i | ~is_fs | (fs_chk_i & ~(sec_yel_i & is_alarm)));
endmodule

// File: rtl/t1_fbit_window.sv
module t1_fbit_window #(
  parameter int unsigned DEPTH = 6,
  parameter int unsigned CNT_W = 3,
  parameter int unsigned TRIP  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             err_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic [DEPTH-1:0] win_q, win_nxt, mask;
  logic [CNT_W-1:0] cnt_cur, cnt_nxt;

  assign win_nxt = {win_q[DEPTH-2:0], err_i};

  for (genvar i = 0; i < DEPTH; i++) begin : g_mask
    assign mask[i] = (CNT_W'(i) < len_i);
  end

  always_comb begin
    cnt_cur = '0;
    cnt_nxt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      cnt_cur = cnt_cur + CNT_W'(win_q[i] & mask[i]);
      cnt_nxt = cnt_nxt + CNT_W'(win_nxt[i] & mask[i]);
    end
  end

  assign cnt_o = cnt_cur;
  assign hit_o = shift_i & (cnt_nxt >= CNT_W'(TRIP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      win_q <= '0;
    else if (clr_i)   win_q <= '0;
    else if (shift_i) win_q <= win_nxt;
  end
endmodule

// File: rtl/t1_fbit_density_mon.sv
module t1_fbit_density_mon
  import t1_fbit_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_stb_i,
  input  logic [FN_W-1:0]  frame_num_i,
  input  logic             f_rx_i,
  input  logic             f_exp_i,
  input  logic             esf_i,
  input  logic             fs_chk_i,
  input  logic             sec_yel_i,
  input  logic [1:0]       thr_sel_i,
  input  logic             transparent_i,
  input  logic             sw_reframe_i,
  output logic             reframe_o,
  output logic [CNT_W-1:0] err_cnt_o
);
  thr_sel_e         thr;
  logic             chk, hit, auto_rf, clr, reframe_q;
  logic [CNT_W-1:0] len;

  assign thr = thr_sel_e'(thr_sel_i);
  assign len = win_len(thr);

  t1_fbit_qual #(.FN_W(FN_W), .ALARM_FN(ALARM_FN)) u_qual (
    .stb_i     (frame_stb_i),
    .fn_i      (frame_num_i),
    .esf_i     (esf_i),
    .fs_chk_i  (fs_chk_i),
    .sec_yel_i (sec_yel_i),
    .chk_o     (chk)
  );

  t1_fbit_window #(.DEPTH(WIN_MAX), .CNT_W(CNT_W), .TRIP(TRIP_ERRS)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (chk),
    .err_i   (f_rx_i ^ f_exp_i),
    .clr_i   (clr),
    .len_i   (len),
    .cnt_o   (err_cnt_o),
    .hit_o   (hit)
  );

  assign auto_rf = hit & (thr != THR_OFF) & ~transparent_i;
  assign clr     = auto_rf | sw_reframe_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reframe_q <= 1'b0;
    else         reframe_q <= clr;
  end

  assign reframe_o = reframe_q;
endmodule

// File: rtl/t1_fbit_density_chk.sv
module t1_fbit_density_chk
  import t1_fbit_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_stb_i,
  input logic [FN_W-1:0]  frame_num_i,
  input logic             f_rx_i,
  input logic             f_exp_i,
  input logic             esf_i,
  input logic             fs_chk_i,
  input logic             sec_yel_i,
  input logic [1:0]       thr_sel_i,
  input logic             transparent_i,
  input logic             sw_reframe_i,
  input logic             reframe_o,
  input logic [CNT_W-1:0] err_cnt_o
);
  // R9
  sw_reframe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_reframe_i |=> reframe_o);

  // R8
  transparent_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (transparent_i && !sw_reframe_i) |=> !reframe_o);

  // R7
  thr_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_sel_i == 2'b11 && !sw_reframe_i) |=> !reframe_o);

  // R10
  reframe_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reframe_o |-> (err_cnt_o == '0));

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_stb_i && !sw_reframe_i) ##1 $stable(thr_sel_i) |-> $stable(err_cnt_o));

  // R12
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!reframe_o && err_cnt_o == '0));
endmodule

bind t1_fbit_density_mon t1_fbit_density_chk u_chk (.*);

// File: tb/t1_fbit_density_mon_tb.sv
module t1_fbit_density_mon_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_stb_i = 1'b0;
  logic [4:0] frame_num_i = 5'd1;
  logic       f_rx_i = 1'b0, f_exp_i = 1'b0;
  logic       esf_i = 1'b0, fs_chk_i = 1'b0, sec_yel_i = 1'b0;
  logic [1:0] thr_sel_i = 2'b00;
  logic       transparent_i = 1'b0, sw_reframe_i = 1'b0;
  logic       reframe_o;
  logic [2:0] err_cnt_o;

  int errors = 0;
  int checks = 0;

  always #4 clk_i = ~clk_i;

  t1_fbit_density_mon u_dut (.*);

  // {req[18:15], thr[14:13], esf[12], fschk[11], secyel[10], fn[9:5], err[4], reframe[3], cnt[2:0]}
  localparam int NV = 44;
  localparam logic [18:0] VEC [NV] = '{
    {4'd2, 2'd0, 1'b0, 1'b0, 1'b0, 5'd2,  1'b1, 1'b0, 3'd0}, // R2 Fs ignored
    {4'd2, 2'd0, 1'b0, 1'b0, 1'b0, 5'd1,  1'b1, 1'b0, 3'd1}, // R2 Ft counted
    {4'd2, 2'd0, 1'b0, 1'b0, 1'b0, 5'd4,  1'b1, 1'b0, 3'd1},
    {4'd2, 2'd0, 1'b0, 1'b0, 1'b0, 5'd3,  1'b0, 1'b0, 3'd1},
    {4'd2, 2'd0, 1'b0, 1'b1, 1'b0, 5'd6,  1'b1, 1'b1, 3'd0}, // R2 Fs counted
    {4'd3, 2'd0, 1'b0, 1'b1, 1'b1, 5'd12, 1'b1, 1'b0, 3'd0}, // R3
    {4'd3, 2'd0, 1'b0, 1'b1, 1'b1, 5'd11, 1'b1, 1'b0, 3'd1},
    {4'd3, 2'd0, 1'b0, 1'b1, 1'b1, 5'd12, 1'b1, 1'b0, 3'd1},
    {4'd3, 2'd0, 1'b0, 1'b1, 1'b1, 5'd10, 1'b1, 1'b1, 3'd0},
    {4'd1, 2'd0, 1'b1, 1'b0, 1'b1, 5'd12, 1'b1, 1'b0, 3'd1}, // R1
    {4'd1, 2'd0, 1'b1, 1'b0, 1'b0, 5'd13, 1'b1, 1'b1, 3'd0},
    {4'd4, 2'd0, 1'b1, 1'b0, 1'b0, 5'd1,  1'b1, 1'b0, 3'd1}, // R4
    {4'd4, 2'd0, 1'b1, 1'b0, 1'b0, 5'd2,  1'b0, 1'b0, 3'd1},
    {4'd4, 2'd0, 1'b1, 1'b0, 1'b0, 5'd3,  1'b0, 1'b0, 3'd1},
    {4'd4, 2'd0, 1'b1, 1'b0, 1'b0, 5'd4,  1'b1, 1'b1, 3'd0},
    {4'd4, 2'd0, 1'b1, 1'b0, 1'b0, 5'd5,  1'b1, 1'b0, 3'd1},
    {4'd4, 2'd0, 1'b1, 1'b0, 1'b0, 5'd6,  1'b0, 1'b0, 3'd1},
    {4'd4, 2'd0, 1'b1, 1'b0, 1'b0, 5'd7,  1'b0, 1'b0, 3'd1},
    {4'd4, 2'd0, 1'b1, 1'b0, 1'b0, 5'd8,  1'b0, 1'b0, 3'd1},
    {4'd4, 2'd0, 1'b1, 1'b0, 1'b0, 5'd9,  1'b1, 1'b0, 3'd1},
    {4'd5, 2'd1, 1'b1, 1'b0, 1'b0, 5'd10, 1'b0, 1'b0, 3'd1}, // R5
    {4'd5, 2'd1, 1'b1, 1'b0, 1'b0, 5'd11, 1'b0, 1'b0, 3'd1},
    {4'd5, 2'd1, 1'b1, 1'b0, 1'b0, 5'd12, 1'b0, 1'b0, 3'd1},
    {4'd5, 2'd1, 1'b1, 1'b0, 1'b0, 5'd13, 1'b1, 1'b1, 3'd0},
    {4'd5, 2'd1, 1'b1, 1'b0, 1'b0, 5'd14, 1'b1, 1'b0, 3'd1},
    {4'd5, 2'd1, 1'b1, 1'b0, 1'b0, 5'd15, 1'b0, 1'b0, 3'd1},
    {4'd5, 2'd1, 1'b1, 1'b0, 1'b0, 5'd16, 1'b0, 1'b0, 3'd1},
    {4'd5, 2'd1, 1'b1, 1'b0, 1'b0, 5'd17, 1'b0, 1'b0, 3'd1},
    {4'd5, 2'd1, 1'b1, 1'b0, 1'b0, 5'd18, 1'b0, 1'b0, 3'd1},
    {4'd5, 2'd1, 1'b1, 1'b0, 1'b0, 5'd19, 1'b1, 1'b0, 3'd1},
    {4'd6, 2'd2, 1'b1, 1'b0, 1'b0, 5'd20, 1'b0, 1'b0, 3'd1}, // R6
    {4'd6, 2'd2, 1'b1, 1'b0, 1'b0, 5'd21, 1'b0, 1'b0, 3'd1},
    {4'd6, 2'd2, 1'b1, 1'b0, 1'b0, 5'd22, 1'b0, 1'b0, 3'd1},
    {4'd6, 2'd2, 1'b1, 1'b0, 1'b0, 5'd23, 1'b0, 1'b0, 3'd1},
    {4'd6, 2'd2, 1'b1, 1'b0, 1'b0, 5'd24, 1'b0, 1'b0, 3'd1},
    {4'd6, 2'd2, 1'b1, 1'b0, 1'b0, 5'd1,  1'b1, 1'b0, 3'd1},
    {4'd6, 2'd2, 1'b1, 1'b0, 1'b0, 5'd2,  1'b0, 1'b0, 3'd1},
    {4'd6, 2'd2, 1'b1, 1'b0, 1'b0, 5'd3,  1'b0, 1'b0, 3'd1},
    {4'd6, 2'd2, 1'b1, 1'b0, 1'b0, 5'd4,  1'b0, 1'b0, 3'd1},
    {4'd6, 2'd2, 1'b1, 1'b0, 1'b0, 5'd5,  1'b0, 1'b0, 3'd1},
    {4'd6, 2'd2, 1'b1, 1'b0, 1'b0, 5'd6,  1'b1, 1'b1, 3'd0},
    {4'd7, 2'd3, 1'b1, 1'b0, 1'b0, 5'd7,  1'b1, 1'b0, 3'd1}, // R7
    {4'd7, 2'd3, 1'b1, 1'b0, 1'b0, 5'd8,  1'b1, 1'b0, 3'd2},
    {4'd7, 2'd3, 1'b1, 1'b0, 1'b0, 5'd9,  1'b1, 1'b0, 3'd3}
  };

  task automatic check(input int req, input logic exp_rf, input logic [2:0] exp_cnt);
    checks++;
    if (reframe_o !== exp_rf || err_cnt_o !== exp_cnt) begin
      errors++;
      $display("FAIL R%0d reframe=%0b cnt=%0d expected reframe=%0b cnt=%0d",
               req, reframe_o, err_cnt_o, exp_rf, exp_cnt);
    end
  endtask

  // one strobed frame; inputs change at negedge, sampled at the next negedge
  task automatic frame(input logic [1:0] thr, input logic esf, input logic fsc, input logic sy,
                       input logic [4:0] fn, input logic err);
    @(negedge clk_i);
    thr_sel_i = thr; esf_i = esf; fs_chk_i = fsc; sec_yel_i = sy;
    frame_num_i = fn; f_exp_i = 1'b1; f_rx_i = ~err; frame_stb_i = 1'b1;
    @(negedge clk_i);
    frame_stb_i = 1'b0;
  endtask

  task automatic sw_pulse();
    @(negedge clk_i);
    sw_reframe_i = 1'b1;
    @(negedge clk_i);
    sw_reframe_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk_i);
    check(12, 1'b0, 3'd0); // R12 in reset
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(12, 1'b0, 3'd0); // R12 after release

    for (int i = 0; i < NV; i++) begin
      frame(VEC[i][14:13], VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9:5], VEC[i][4]);
      check(int'(VEC[i][18:15]), VEC[i][3], VEC[i][2:0]);
    end
    // window now holds three errors, select 11

    // R8: transparent blocks the trip; 4 errors in a 4-wide window
    @(negedge clk_i); transparent_i = 1'b1;
    frame(2'd0, 1'b1, 1'b0, 1'b0, 5'd10, 1'b1);
    check(8, 1'b0, 3'd4);
    @(negedge clk_i);
    check(8, 1'b0, 3'd4);

    // R9 / R10: software reframe clears history even in transparent mode
    sw_pulse();
    check(9, 1'b1, 3'd0);
    @(negedge clk_i);
    check(10, 1'b0, 3'd0);
    transparent_i = 1'b0;

    // R11: count holds over idle cycles
    frame(2'd0, 1'b1, 1'b0, 1'b0, 5'd11, 1'b1);
    check(11, 1'b0, 3'd1);
    repeat (3) @(negedge clk_i);
    check(11, 1'b0, 3'd1);

    // R10: auto reframe lasts one cycle
    frame(2'd0, 1'b1, 1'b0, 1'b0, 5'd12, 1'b1);
    check(10, 1'b1, 3'd0);
    @(negedge clk_i);
    check(10, 1'b0, 3'd0);

    // R9: software reframe with auto reframe off
    @(negedge clk_i); thr_sel_i = 2'd3;
    sw_pulse();
    check(9, 1'b1, 3'd0);

    // R11: count follows the window select
    frame(2'd3, 1'b1, 1'b0, 1'b0, 5'd1, 1'b1);
    frame(2'd3, 1'b1, 1'b0, 1'b0, 5'd2, 1'b0);
    frame(2'd3, 1'b1, 1'b0, 1'b0, 5'd3, 1'b0);
    frame(2'd3, 1'b1, 1'b0, 1'b0, 5'd4, 1'b0);
    frame(2'd3, 1'b1, 1'b0, 1'b0, 5'd5, 1'b1);
    check(11, 1'b0, 3'd2);
    @(negedge clk_i); thr_sel_i = 2'd0;
    @(negedge clk_i);
    check(11, 1'b0, 3'd1);

    // R12: reset mid-run clears the count
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    check(12, 1'b0, 3'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(12, 1'b0, 3'd0);

    finish_run();
  end
endmodule